// File: doc/BRIEF.md
# Programmable Width One-Shot Generator

This block is a synchronous one-shot. A rising edge on the trigger input starts exactly one output pulse. After a fixed start latency the pulse goes high. It stays high for a number of clock cycles set by a 12-bit width code: a base width plus the code times a per-step increment. The block drives the pulse and its complement.

While a pulse is being prepared or is high, further trigger edges have no effect. A short recovery window after the pulse falls also ignores triggers. The width code is not captured when the pulse starts. The block compares the pulse length against the code on every cycle, so the code must stay valid for the whole pulse, and a change during the pulse moves its end. Reset parks the outputs at once and returns the block to idle.

Top module: `pw_oneshot`

## Requirements
- R1: While `rst` is high, `pulse_o` is 0 and `pulse_n_o` is 1 in that same cycle, including when a pulse was in progress.
- R2: With default parameters, if `trig_i` is first sampled high at clock edge E0 and the block is idle, `pulse_o` is low after edges E0, E0+1 and E0+2 and high after edge E0+3. In general it rises after edge E0+2+START_DLY, counting the two synchronizer stages.
- R3: Only a low-to-high transition of `trig_i` starts a pulse. Holding `trig_i` high, or taking it low, starts nothing.
- R4: The pulse stays high for BASE_W + STEP_W × code cycles. With defaults (base 2, step 1), code 0 gives 2 cycles and code 4095 gives 4097 cycles, with no overflow.
- R5: A trigger edge that reaches the controller during the start delay or while the pulse is high is ignored, and no pulse follows later because of it.
- R6: After the pulse falls at edge F, triggers are ignored for RECOV_CYC cycles. With defaults, a trigger first sampled high at edge F−1 produces no pulse, and one first sampled high at edge F produces a pulse with the normal R2 latency.
- R7: The code is not latched. If the code is lowered during a pulse so that the cycles already spent high reach the new width, the pulse ends at the next edge. If the code is raised, the pulse lasts the new width.
- R8: `pulse_n_o` is always the complement of `pulse_o`.
- R9: After `rst` is released with `trig_i` low, the block is idle. A later trigger gives a pulse with the R2 latency and the R4 width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high reset; aborts any pulse and parks the outputs |
| trig_i | input | 1 | Trigger; may be asynchronous, and its rising edge starts a pulse |
| code_i | input | 12 | Width code; must stay valid for the whole pulse |
| pulse_o | output | 1 | True pulse output |
| pulse_n_o | output | 1 | Complement of pulse_o |

## Verification
The assertions assume that `trig_i` reaches the controller only through the two-flop synchronizer, so a detected edge lasts one cycle. They also assume that reset is applied before the first trigger. The bench drives `trig_i` and `code_i` only on falling clock edges, and it holds `rst` high for several cycles at the start. The bench changes the code during a pulse only in the directed R7 cases. Those cases check the end against the width that applies at the moment of the change.

// File: rtl/pw_oneshot_pkg.sv
package pw_oneshot_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_HIGH = 2'd2,
        ST_HOLD = 2'd3
    } os_state_e;

    // Bits needed to hold the value v (at least 1)
    function automatic int bits_for(input longint v);
        int n;
        n = 1;
        while ((longint'(1) << n) <= v) n++;
        return n;
    endfunction

    // Largest programmable width in cycles
    function automatic longint max_width(input int code_w, input int base_w, input int step_w);
        return longint'(base_w) + longint'(step_w) * ((longint'(1) << code_w) - 1);
    endfunction

endpackage

// File: rtl/pw_trig_sync.sv
module pw_trig_sync (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic rise_o
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= trig_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise_o = sync_q & ~prev_q;

    // R3: a detected edge lasts exactly one cycle
    assert_single_rise_R3: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/pw_width_calc.sv
module pw_width_calc #(
    parameter int CODE_W = 12,
    parameter int BASE_W = 2,
    parameter int STEP_W = 1,
    parameter int WID_W  = 13
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [WID_W-1:0]  width_o
);
    localparam logic [WID_W-1:0] BASE_V = WID_W'(BASE_W);
    localparam logic [WID_W-1:0] STEP_V = WID_W'(STEP_W);

    logic [WID_W-1:0] code_ext;
    assign code_ext = WID_W'(code_i);

    generate
        if (STEP_W == 1) begin : g_unit_step
            assign width_o = BASE_V + code_ext;
        end else begin : g_scaled_step
            assign width_o = BASE_V + STEP_V * code_ext;
        end
    endgenerate

endmodule

// File: rtl/pw_ctrl.sv
module pw_ctrl
    import pw_oneshot_pkg::*;
#(
    parameter int WID_W     = 13,
    parameter int START_DLY = 1,
    parameter int RECOV_CYC = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise_i,
    input  logic [WID_W-1:0] width_i,
    output logic             high_o
);
    localparam int CNT_MAX = (START_DLY > RECOV_CYC) ? START_DLY : RECOV_CYC;
    localparam int CNT_W   = bits_for(longint'(CNT_MAX));
    localparam logic [CNT_W-1:0] DLY_LOAD = CNT_W'((START_DLY > 0) ? START_DLY - 1 : 0);
    localparam logic [CNT_W-1:0] REC_LOAD = CNT_W'((RECOV_CYC > 0) ? RECOV_CYC - 1 : 0);

    os_state_e        state_q;
    logic [CNT_W-1:0] dcnt_q;
    logic [WID_W-1:0] elap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            dcnt_q  <= '0;
            elap_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (rise_i) begin
                        if (START_DLY == 0) begin
                            state_q <= ST_HIGH;
                            elap_q  <= WID_W'(1);
                        end else begin
                            state_q <= ST_WAIT;
                            dcnt_q  <= DLY_LOAD;
                        end
                    end
                end
                ST_WAIT: begin
                    if (dcnt_q == '0) begin
                        state_q <= ST_HIGH;
                        elap_q  <= WID_W'(1);
                    end else begin
                        dcnt_q <= dcnt_q - 1'b1;
                    end
                end
                ST_HIGH: begin
                    // live comparison: code is not latched
                    if (elap_q >= width_i) begin
                        if (RECOV_CYC == 0) begin
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_HOLD;
                            dcnt_q  <= REC_LOAD;
                        end
                    end else begin
                        elap_q <= elap_q + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (dcnt_q == '0) state_q <= ST_IDLE;
                    else              dcnt_q  <= dcnt_q - 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign high_o = (state_q == ST_HIGH);

    // R2 / R5: the start sequence only begins from an accepted edge
    assert_start_from_edge_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q == ST_WAIT) |-> $past(rise_i));

    // R9: the cycle after reset release finds the block idle
    assert_idle_after_reset_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state_q == ST_IDLE));

    generate
        if (START_DLY > 0) begin : g_chk_dly
            // R2: the pulse rises only at the end of the start delay
            assert_rise_after_wait_R2: assert property (@(posedge clk) disable iff (rst)
                $rose(high_o) |-> $past(state_q == ST_WAIT));
        end
        if (RECOV_CYC > 0) begin : g_chk_rec
            // R6: every falling edge enters the recovery lockout
            assert_hold_after_fall_R6: assert property (@(posedge clk) disable iff (rst)
                $fell(high_o) |-> (state_q == ST_HOLD));
        end
    endgenerate

endmodule

// File: rtl/pw_oneshot.sv
module pw_oneshot
    import pw_oneshot_pkg::*;
#(
    parameter int CODE_W    = 12,
    parameter int BASE_W    = 2,
    parameter int STEP_W    = 1,
    parameter int START_DLY = 1,
    parameter int RECOV_CYC = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              pulse_o,
    output logic              pulse_n_o
);
    localparam int WID_W = bits_for(max_width(CODE_W, BASE_W, STEP_W));

    logic             rise;
    logic [WID_W-1:0] width;
    logic             high;

    pw_trig_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .trig_i (trig_i),
        .rise_o (rise)
    );

    pw_width_calc #(
        .CODE_W (CODE_W),
        .BASE_W (BASE_W),
        .STEP_W (STEP_W),
        .WID_W  (WID_W)
    ) u_width (
        .code_i  (code_i),
        .width_o (width)
    );

    pw_ctrl #(
        .WID_W     (WID_W),
        .START_DLY (START_DLY),
        .RECOV_CYC (RECOV_CYC)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .rise_i  (rise),
        .width_i (width),
        .high_o  (high)
    );

    // reset gates the output combinationally so it parks at once
    assign pulse_o   = high & ~rst;
    assign pulse_n_o = ~pulse_o;

    // R1: reset parks both outputs
    assert_reset_park_R1: assert property (@(posedge clk)
        rst |-> (!pulse_o && pulse_n_o));

    // R8: outputs are complementary
    assert_complement_R8: assert property (@(posedge clk) disable iff (rst)
        pulse_n_o != pulse_o);

endmodule

// File: tb/pw_oneshot_test.sv
module pw_oneshot_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {code, expected width} with base 2, step 1
    localparam int VEC [NVEC][2] = '{
        '{0, 2}, '{1, 3}, '{2, 4}, '{7, 9}, '{100, 102}, '{4095, 4097}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig = 1'b0;
    logic [11:0] code = '0;
    logic        pulse, pulse_n;

    int checks = 0;
    int fails  = 0;

    pw_oneshot uut (
        .clk       (clk),
        .rst       (rst),
        .trig_i    (trig),
        .code_i    (code),
        .pulse_o   (pulse),
        .pulse_n_o (pulse_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        check(pulse_n === ~pulse, "R8 complement", int'(pulse_n), int'(~pulse));
    endtask

    // trig was raised at the current negedge; check latency then width
    task automatic measure(input int expw, input string req);
        bit early = 0;
        int w;
        for (int k = 0; k < 3; k++) begin
            tick();
            if (pulse) early = 1;
        end
        check(!early, "R2 low during latency", int'(early), 0);
        tick();
        check(pulse === 1'b1, "R2 high after latency", int'(pulse), 1);
        w = 1;
        forever begin
            tick();
            if (!pulse) break;
            w++;
            if (w > 9000) break;
        end
        check(w == expw, req, w, expw);
    endtask

    task automatic expect_quiet(input int n, input string req);
        bit seen = 0;
        for (int k = 0; k < n; k++) begin
            tick();
            if (pulse) seen = 1;
        end
        check(!seen, req, int'(seen), 0);
    endtask

    task automatic settle();
        trig = 1'b0;
        repeat (4) tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) tick();
        check(pulse === 1'b0 && pulse_n === 1'b1, "R1 reset state", int'(pulse), 0);
        rst = 1'b0;
        repeat (2) tick();

        // table walk: R4 widths, R9 first pulse after reset
        for (int i = 0; i < NVEC; i++) begin
            code = 12'(VEC[i][0]);
            trig = 1'b1;
            measure(VEC[i][1], "R4 width (R9 after reset)");
            settle();
        end

        // R5: edge mid-pulse ignored; R3: held-high then falling gives nothing
        code = 12'd10;
        trig = 1'b1;
        repeat (3) tick();
        tick();
        trig = 1'b0;
        tick();
        trig = 1'b1;
        begin
            int w = 2;
            forever begin
                tick();
                if (!pulse) break;
                w++;
                if (w > 100) break;
            end
            check(w == 12, "R5 width unchanged by mid-pulse edge", w, 12);
        end
        expect_quiet(25, "R5 R3 no pulse from ignored or held trigger");
        trig = 1'b0;
        expect_quiet(10, "R3 falling edge starts nothing");

        // R6 case A: trigger first sampled at F-1 is ignored
        code = 12'd5;
        trig = 1'b1;
        repeat (4) tick();
        trig = 1'b0;
        repeat (5) tick();
        check(pulse === 1'b1, "R6 pulse still high at sixth cycle", int'(pulse), 1);
        trig = 1'b1;
        tick();
        check(pulse === 1'b1, "R6 seventh cycle high", int'(pulse), 1);
        tick();
        check(pulse === 1'b0, "R6 pulse fell", int'(pulse), 0);
        expect_quiet(20, "R6 trigger in recovery ignored");
        settle();

        // R6 case B: trigger first sampled at F is accepted
        trig = 1'b1;
        repeat (4) tick();
        trig = 1'b0;
        repeat (6) tick();
        check(pulse === 1'b1, "R6 last high cycle", int'(pulse), 1);
        trig = 1'b1;
        measure(7, "R6 boundary trigger accepted");
        settle();

        // R7: code lowered mid-pulse ends the pulse at next edge
        code = 12'd20;
        trig = 1'b1;
        repeat (4) tick();
        repeat (2) tick();
        code = 12'd0;
        tick();
        check(pulse === 1'b0, "R7 lowered code ends pulse", int'(pulse), 0);
        settle();

        // R7: code raised mid-pulse stretches the pulse
        code = 12'd0;
        trig = 1'b1;
        repeat (4) tick();
        code = 12'd10;
        begin
            int w = 1;
            forever begin
                tick();
                if (!pulse) break;
                w++;
                if (w > 100) break;
            end
            check(w == 12, "R7 raised code width", w, 12);
        end
        settle();

        // R1: reset mid-pulse parks outputs at once; R9: clean restart
        code = 12'd50;
        trig = 1'b1;
        repeat (6) tick();
        rst  = 1'b1;
        trig = 1'b0;
        #1;
        check(pulse === 1'b0 && pulse_n === 1'b1, "R1 reset parks mid-pulse", int'(pulse), 0);
        repeat (3) tick();
        check(pulse === 1'b0, "R1 held in reset", int'(pulse), 0);
        rst = 1'b0;
        expect_quiet(5, "R9 idle after release");
        code = 12'd3;
        trig = 1'b1;
        measure(5, "R9 pulse after reset release");
        settle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule